// File: doc/BRIEF.md
# USB Host IN Data-Toggle Checker

This block handles the data phase of a Bulk or Interrupt IN transaction inside a full-speed USB host serial engine. For each endpoint it keeps one expected toggle bit. For each received packet it receives the token context (endpoint index and an isochronous flag), the decoded PID, the payload bytes and the end-of-packet CRC verdict. From these it decides three things: whether the payload reaches the endpoint buffer, whether an ACK handshake is requested, and how the toggle moves.

The toggle check works the same way on every endpoint index. When the PID disagrees with the expected toggle, the packet is still acknowledged but its payload is dropped. This stops a device from retransmitting the same packet forever. The mismatch also sets a sticky flag that software clears. Software can preload any endpoint's toggle, for example to DATA1 for a device that wrongly opens its stream with DATA1. Isochronous packets skip both the handshake and the toggle check.

Top module: `usb_in_toggle_chk`

## Requirements
- R1: After reset, every endpoint's expected toggle reads 0, `seq_err` is 0, and `commit`, `discard` and `hs_ack` are low.
- R2: The PID codes are DATA0 = 4'b0011 and DATA1 = 4'b1011 (bit 3 gives the toggle). A non-isochronous packet is accepted when its PID matches the endpoint's toggle and its CRC is good. For an accepted packet, each byte appears on `wr_valid`/`wr_data` in the cycle it arrives, `commit` pulses for one cycle in the cycle after EOP, and the toggle flips.
- R3: A handshake request `hs_ack` is a one-cycle pulse that rises `ACK_DLY` cycles after the EOP cycle. `ACK_DLY` must lie between 1 and the turnaround budget `TURN_MAX`; this is checked at elaboration.
- R4: When the PID does not match the toggle and the CRC is good, `hs_ack` is still raised. No payload byte is forwarded, `discard` pulses instead of `commit`, and the toggle is left unchanged.
- R5: A toggle mismatch with good CRC sets `seq_err`. The flag stays set until `seq_err_clr` is asserted; an accepted packet does not clear it.
- R6: A packet with bad CRC or bit-stuff status produces no `hs_ack` and no `commit`. It pulses `discard`, leaves the toggle unchanged and does not set `seq_err`.
- R7: An isochronous packet with good CRC is committed whatever its data PID. It produces no `hs_ack`, leaves the toggle unchanged and never sets `seq_err`.
- R8: The toggle check and handshake behave the same on any endpoint index, low or high.
- R9: A write with `cfg_we` loads `cfg_tog` into the toggle of endpoint `cfg_ep`. The value reads back on `rd_tog`, and it decides which PID the next packet must carry.
- R10: When a packet with the wrong PID is followed by a retransmission with the correct PID, both packets are acknowledged, exactly one payload is committed, and the toggle flips exactly once.
- R11: A PID that is neither DATA0 nor DATA1 ends the data phase. A following EOP then causes no `commit`, `discard` or `hs_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Toggle preload strobe |
| cfg_ep | input | EP_W | Endpoint index for the preload |
| cfg_tog | input | 1 | Toggle value to preload |
| tok_valid | input | 1 | IN token issued; starts a data phase |
| tok_ep | input | EP_W | Endpoint index of the token |
| tok_iso | input | 1 | Endpoint is isochronous |
| rx_pid_valid | input | 1 | Decoded PID strobe |
| rx_pid | input | 4 | Decoded PID code |
| rx_byte_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_eop_valid | input | 1 | End-of-packet strobe |
| rx_crc_ok | input | 1 | CRC and bit-stuff status, valid with EOP |
| seq_err_clr | input | 1 | Clears the sequence-error flag |
| rd_ep | input | EP_W | Endpoint whose toggle is read back |
| rd_tog | output | 1 | Toggle of endpoint `rd_ep` |
| wr_valid | output | 1 | Byte write to the endpoint buffer |
| wr_data | output | 8 | Byte to write |
| commit | output | 1 | Payload accepted pulse |
| discard | output | 1 | Payload dropped pulse |
| hs_ack | output | 1 | ACK handshake request pulse |
| seq_err | output | 1 | Sticky data-sequence error flag |

## Verification
Forwarded bytes are combinational and are checked in the same cycle the byte is driven. `commit`, `discard`, `seq_err` and the toggle update are due one cycle after the EOP cycle. `hs_ack` is due exactly `ACK_DLY` cycles after EOP. Each scenario task drives its inputs just after a rising edge and records the cycle number at which EOP was captured. A falling-edge monitor counts every pulse and stamps the cycle of each ACK, so the checks compare exact counts and the exact ACK cycle against that EOP stamp. Toggle values are read through `rd_ep`/`rd_tog` only after the pulses have settled.

// File: rtl/utc_pkg.sv
package utc_pkg;
   localparam logic [3:0] PID_DATA0 = 4'b0011;
   localparam logic [3:0] PID_DATA1 = 4'b1011;

   typedef enum logic [1:0] {ST_IDLE, ST_PID, ST_DATA} utc_state_e;

   function automatic logic pid_is_data(input logic [3:0] p);
      return (p == PID_DATA0) || (p == PID_DATA1);
   endfunction
endpackage

// File: rtl/utc_tog_bank.sv
module utc_tog_bank #(
   parameter int NUM_EP = 16,
   parameter int EP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [EP_W-1:0]   cfg_ep,
   input  logic              cfg_tog,
   input  logic              flip_en,
   input  logic [EP_W-1:0]   flip_ep,
   output logic [NUM_EP-1:0] tog_vec
);
   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      always_ff @(posedge clk) begin
         if (!rst_n)
            tog_vec[i] <= 1'b0;
         else if (cfg_we && cfg_ep == EP_W'(i))
            tog_vec[i] <= cfg_tog;
         else if (flip_en && flip_ep == EP_W'(i))
            tog_vec[i] <= ~tog_vec[i];
      end
   end
endmodule

// File: rtl/utc_ack_delay.sv
module utc_ack_delay #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_out
);
   if (DLY <= 1) begin : g_direct
      assign req_out = req_in;
   end else begin : g_line
      logic [DLY-2:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh[0] <= 1'b0;
         else        sh[0] <= req_in;
      end
      for (genvar k = 1; k < DLY-1; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) sh[k] <= 1'b0;
            else        sh[k] <= sh[k-1];
         end
      end
      assign req_out = sh[DLY-2];
   end
endmodule

// File: rtl/usb_in_toggle_chk.sv
module usb_in_toggle_chk
   import utc_pkg::*;
#(
   parameter int NUM_EP   = 16,
   parameter int ACK_DLY  = 2,
   parameter int TURN_MAX = 7,
   parameter int EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [EP_W-1:0] cfg_ep,
   input  logic            cfg_tog,
   input  logic            tok_valid,
   input  logic [EP_W-1:0] tok_ep,
   input  logic            tok_iso,
   input  logic            rx_pid_valid,
   input  logic [3:0]      rx_pid,
   input  logic            rx_byte_valid,
   input  logic [7:0]      rx_byte,
   input  logic            rx_eop_valid,
   input  logic            rx_crc_ok,
   input  logic            seq_err_clr,
   input  logic [EP_W-1:0] rd_ep,
   output logic            rd_tog,
   output logic            wr_valid,
   output logic [7:0]      wr_data,
   output logic            commit,
   output logic            discard,
   output logic            hs_ack,
   output logic            seq_err
);
   if (ACK_DLY < 1 || ACK_DLY > TURN_MAX) begin : g_bad_dly
      $error("ACK_DLY must be within 1..TURN_MAX");
   end
   if (NUM_EP < 1) begin : g_bad_ep
      $error("NUM_EP must be at least 1");
   end

   utc_state_e       state;
   logic [EP_W-1:0]  cur_ep;
   logic             cur_iso;
   logic             cur_match;
   logic [NUM_EP-1:0] tog_vec;
   logic             exp_tog;
   logic             in_data, eop_here, good;
   logic             do_commit, do_discard, do_ack, do_flip, do_seq;
   logic             ack_req;

   assign exp_tog  = tog_vec[cur_ep];
   assign rd_tog   = tog_vec[rd_ep];
   assign in_data  = (state == ST_DATA);
   assign eop_here = in_data && rx_eop_valid;
   assign good     = eop_here && rx_crc_ok;

   assign do_commit  = good && cur_match;
   assign do_discard = eop_here && !(rx_crc_ok && cur_match);
   assign do_ack     = good && !cur_iso;
   assign do_flip    = good && cur_match && !cur_iso;
   assign do_seq     = good && !cur_match;

   assign wr_valid = in_data && rx_byte_valid && cur_match;
   assign wr_data  = rx_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_ep    <= '0;
         cur_iso   <= 1'b0;
         cur_match <= 1'b0;
      end else if (tok_valid) begin
         state   <= ST_PID;
         cur_ep  <= tok_ep;
         cur_iso <= tok_iso;
      end else begin
         case (state)
            ST_PID: if (rx_pid_valid) begin
               if (pid_is_data(rx_pid)) begin
                  state     <= ST_DATA;
                  cur_match <= cur_iso || (rx_pid[3] == exp_tog);
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_DATA: if (rx_eop_valid) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit  <= 1'b0;
         discard <= 1'b0;
         ack_req <= 1'b0;
         seq_err <= 1'b0;
      end else begin
         commit  <= do_commit;
         discard <= do_discard;
         ack_req <= do_ack;
         if (do_seq)           seq_err <= 1'b1;
         else if (seq_err_clr) seq_err <= 1'b0;
      end
   end

   utc_tog_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_tog(cfg_tog),
      .flip_en(do_flip), .flip_ep(cur_ep),
      .tog_vec(tog_vec)
   );

   utc_ack_delay #(.DLY(ACK_DLY)) u_ack (
      .clk(clk), .rst_n(rst_n), .req_in(ack_req), .req_out(hs_ack)
   );
endmodule

// File: rtl/utc_checker.sv
module utc_checker (
   input logic clk,
   input logic rst_n,
   input logic in_data,
   input logic rx_eop_valid,
   input logic commit,
   input logic discard,
   input logic hs_ack,
   input logic seq_err,
   input logic seq_err_clr
);
   // R2: every EOP seen in the data phase resolves to commit or discard
   p_eop_resolves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_data && rx_eop_valid |=> commit || discard);

   // R3: handshake request is one cycle wide
   p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |=> !hs_ack);

   // R6: a packet is never both committed and dropped
   p_commit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && discard));

   // R5: the sequence flag holds until cleared
   p_seq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err && !seq_err_clr |=> seq_err);

   // R4: a new sequence error always comes with a dropped payload
   p_seq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> discard);
endmodule

bind usb_in_toggle_chk utc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_data(in_data), .rx_eop_valid(rx_eop_valid),
   .commit(commit), .discard(discard), .hs_ack(hs_ack),
   .seq_err(seq_err), .seq_err_clr(seq_err_clr)
);

// File: tb/usb_in_toggle_chk_test.sv
module usb_in_toggle_chk_test;
   localparam int NUM_EP  = 16;
   localparam int ACK_DLY = 2;
   localparam int EP_W    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_tog = 0, tok_valid = 0, tok_iso = 0;
   logic [EP_W-1:0] cfg_ep = '0, tok_ep = '0, rd_ep = '0;
   logic rx_pid_valid = 0, rx_byte_valid = 0, rx_eop_valid = 0, rx_crc_ok = 0, seq_err_clr = 0;
   logic [3:0] rx_pid = '0;
   logic [7:0] rx_byte = '0;
   logic rd_tog, wr_valid, commit, discard, hs_ack, seq_err;
   logic [7:0] wr_data;

   always #2 clk = ~clk;

   usb_in_toggle_chk #(.NUM_EP(NUM_EP), .ACK_DLY(ACK_DLY)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_tog(cfg_tog),
      .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_iso(tok_iso),
      .rx_pid_valid(rx_pid_valid), .rx_pid(rx_pid),
      .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
      .rx_eop_valid(rx_eop_valid), .rx_crc_ok(rx_crc_ok),
      .seq_err_clr(seq_err_clr), .rd_ep(rd_ep), .rd_tog(rd_tog),
      .wr_valid(wr_valid), .wr_data(wr_data), .commit(commit), .discard(discard),
      .hs_ack(hs_ack), .seq_err(seq_err)
   );

   int n_chk = 0, n_err = 0;
   int cyc = 0;
   int n_commit = 0, n_discard = 0, n_ack = 0, n_wr = 0, last_ack = -1;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (commit)   n_commit++;
      if (discard)  n_discard++;
      if (hs_ack) begin n_ack++; last_ack = cyc; end
      if (wr_valid) n_wr++;
   end

   task automatic check(input int act, input int exp, input string msg);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic read_tog(input int ep, output int t);
      rd_ep = EP_W'(ep);
      #1 t = int'(rd_tog);
   endtask

   // one IN data phase; checks pulse counts and ACK timing
   task automatic run_pkt(input int ep, input bit iso, input logic [3:0] pid,
                          input int nbytes, input bit crc,
                          input int e_commit, input int e_discard,
                          input int e_ack, input int e_wr, input string tag);
      int c0, d0, a0, w0, eop_cyc;
      c0 = n_commit; d0 = n_discard; a0 = n_ack; w0 = n_wr;
      step();
      tok_valid = 1; tok_ep = EP_W'(ep); tok_iso = iso;
      step();
      tok_valid = 0; rx_pid_valid = 1; rx_pid = pid;
      step();
      rx_pid_valid = 0;
      for (int b = 0; b < nbytes; b++) begin
         rx_byte_valid = 1; rx_byte = 8'(8'h40 + b);
         step();
      end
      rx_byte_valid = 0;
      rx_eop_valid = 1; rx_crc_ok = crc;
      step();
      rx_eop_valid = 0; rx_crc_ok = 0;
      eop_cyc = cyc;
      repeat (ACK_DLY + 3) step();
      check(n_commit - c0, e_commit, {tag, " commit count"});
      check(n_discard - d0, e_discard, {tag, " discard count"});
      check(n_ack - a0, e_ack, {tag, " ack count"});
      check(n_wr - w0, e_wr, {tag, " bytes forwarded"});
      if (e_ack > 0) check(last_ack, eop_cyc + ACK_DLY - 1, {tag, " ack cycle R3"});
   endtask

   task automatic t_reset();
      int t;
      for (int e = 0; e < NUM_EP; e += 5) begin
         read_tog(e, t);
         check(t, 0, "R1 toggle after reset");
      end
      check(int'(seq_err), 0, "R1 seq_err after reset");
      check(n_commit + n_discard + n_ack, 0, "R1 no pulses after reset");
   endtask

   task automatic t_match();
      int t;
      run_pkt(1, 0, 4'b0011, 3, 1, 1, 0, 1, 3, "R2 DATA0 match");
      read_tog(1, t); check(t, 1, "R2 toggle flips to 1");
      run_pkt(1, 0, 4'b1011, 2, 1, 1, 0, 1, 2, "R2 DATA1 match");
      read_tog(1, t); check(t, 0, "R2 toggle flips back to 0");
   endtask

   task automatic t_mismatch();
      int t;
      run_pkt(1, 0, 4'b1011, 4, 1, 0, 1, 1, 0, "R4 mismatch acked");
      read_tog(1, t); check(t, 0, "R4 toggle unchanged");
      check(int'(seq_err), 1, "R5 seq_err set");
      run_pkt(1, 0, 4'b0011, 1, 1, 1, 0, 1, 1, "R5 good packet after error");
      check(int'(seq_err), 1, "R5 seq_err sticky");
      step(); seq_err_clr = 1; step(); seq_err_clr = 0; step();
      check(int'(seq_err), 0, "R5 seq_err cleared");
   endtask

   task automatic t_crcbad();
      int t;
      run_pkt(2, 0, 4'b0011, 3, 0, 0, 1, 0, 3, "R6 bad crc");
      read_tog(2, t); check(t, 0, "R6 toggle unchanged");
      check(int'(seq_err), 0, "R6 no seq_err");
   endtask

   task automatic t_iso();
      int t;
      run_pkt(3, 1, 4'b1011, 2, 1, 1, 0, 0, 2, "R7 iso any pid");
      read_tog(3, t); check(t, 0, "R7 iso toggle unchanged");
      check(int'(seq_err), 0, "R7 iso no seq_err");
   endtask

   task automatic t_index();
      int t;
      run_pkt(14, 0, 4'b1011, 2, 1, 0, 1, 1, 0, "R8 high ep mismatch");
      check(int'(seq_err), 1, "R8 high ep seq_err");
      run_pkt(14, 0, 4'b0011, 2, 1, 1, 0, 1, 2, "R8 high ep match");
      read_tog(14, t); check(t, 1, "R8 high ep toggle");
      step(); seq_err_clr = 1; step(); seq_err_clr = 0;
   endtask

   task automatic t_preload();
      int t;
      step(); cfg_we = 1; cfg_ep = 4'd5; cfg_tog = 1; step(); cfg_we = 0;
      read_tog(5, t); check(t, 1, "R9 preload readback");
      run_pkt(5, 0, 4'b1011, 2, 1, 1, 0, 1, 2, "R9 DATA1 first accepted");
      read_tog(5, t); check(t, 0, "R9 toggle after preload packet");
      check(int'(seq_err), 0, "R9 no seq_err");
   endtask

   task automatic t_retx();
      int t, c0, a0;
      c0 = n_commit; a0 = n_ack;
      run_pkt(6, 0, 4'b1011, 4, 1, 0, 1, 1, 0, "R10 wrong first pid");
      run_pkt(6, 0, 4'b0011, 4, 1, 1, 0, 1, 4, "R10 retransmission");
      check(n_commit - c0, 1, "R10 exactly one commit");
      check(n_ack - a0, 2, "R10 both acked");
      read_tog(6, t); check(t, 1, "R10 single toggle flip");
      step(); seq_err_clr = 1; step(); seq_err_clr = 0;
   endtask

   task automatic t_nondata();
      int t;
      run_pkt(7, 0, 4'b1001, 2, 1, 0, 0, 0, 0, "R11 non-data pid");
      read_tog(7, t); check(t, 0, "R11 toggle untouched");
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      step();
      t_reset();
      t_match();
      t_mismatch();
      t_crcbad();
      t_iso();
      t_index();
      t_preload();
      t_retx();
      t_nondata();
      done = 1;
      finish_run();
   end
endmodule